// File: doc/BRIEF.md
# DES Round Subkey Pool

This block turns one 64-bit DES key into the full set of sixteen 48-bit round subkeys during the cycle in which the key is offered. It then hands each subkey to its own round stage of an unrolled sixteen-stage cipher pipeline. The key is stripped of its parity bits and split into two 28-bit halves. Each half is rotated by the total amount that applies to its round, and the 56 rotated bits are compressed to 48. All sixteen of these paths exist side by side as combinational logic.

Round stage n sits n pipeline registers away from the entry point. The subkey for stage n therefore travels through a chain of n registers, so it reaches stage n in the same cycle as the data block that entered alongside its key. A mode bit taken with the key picks the decryption schedule. In that schedule the halves are rotated right, starting from an unrotated first round, and the subkeys come out in reverse round order. Since every key carries its own subkeys down the chains, a new key and mode may be offered on every clock. Each stage also outputs a valid flag that tracks its slot. An empty slot carries an all-zero subkey.

The block has no state machine. Its only sequential state is the set of register chains, one per stage, which are cleared by a synchronous reset.

Top module: `des_subkey_pool`

## Requirements
- R1: The key bits at vector positions 0, 8, 16, 24, 32, 40, 48 and 56 (the per-byte parity bits) have no effect on any subkey.
- R2: With `key_decrypt_i` = 0, stage n carries the standard DES encryption subkey for round n. DES bit 1 of the key is `key_i[63]`, and DES bit 1 of a subkey is the most significant bit of its slice. The cumulative left rotations per round are built from the per-round steps 1,1,2,2,2,2,2,2,1,2,2,2,2,2,2,1. For key 133457799BBCDFF1, round 1 is 1B02EFFC7072 and round 16 is CB3D8B0E17F5.
- R3: With `key_decrypt_i` = 1, stage n carries the encryption subkey of round 17-n. For example, stage 1 equals encryption round 16.
- R4: A key sampled with `key_vld_i` = 1 at a rising edge appears on stage n after the n-th rising edge, counting the sampling edge as the first. A lone key therefore makes `stage_vld_o` one-hot at bit k-1 after edge k.
- R5: Keys and modes that change on every consecutive cycle are each paired with their own subkeys at every stage, with no mixing between neighbouring keys.
- R6: `stage_vld_o[n-1]` follows `key_vld_i` with the same delay as stage n's subkey.
- R7: A stage whose slot is empty (valid low) shows an all-zero subkey.
- R8: A synchronous active-high reset clears every stage valid and every subkey to zero at the next edge, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| key_vld_i | input | 1 | Key and mode are offered this cycle |
| key_decrypt_i | input | 1 | 1 selects the reverse (decryption) schedule |
| key_i | input | 64 | DES key; bit 63 is DES bit 1 |
| stage_vld_o | output | 16 | Bit n-1 marks a live subkey at stage n |
| subkeys_o | output | 768 | Stage n subkey in bits [(n-1)*48 +: 48] |

## Verification
The hardest situation to bring about is a full pipeline in which all sixteen chains hold subkeys from sixteen different keys. Those keys alternate randomly between encryption and decryption, and some slots are empty, so any cross-wiring of rounds, stages or modes shows up as a mismatch at some stage. A long stream of seeded random keys is driven back to back, mostly valid with scattered gaps, and every stage is checked on every cycle against a bench model that keeps the history of the inputs. Directed cases add the published round vectors in both directions, a lone key that exposes the latency of each stage, a key whose parity bits are inverted, and a reset asserted while the pipeline is full.

// File: rtl/des_ks_pkg.sv
package des_ks_pkg;

    localparam int KEY_W    = 64;
    localparam int HALF_W   = 28;
    localparam int CD_W     = 2 * HALF_W;
    localparam int SK_W     = 48;
    localparam int N_ROUNDS = 16;
    localparam int POOL_W   = N_ROUNDS * SK_W;

    // Source DES bit (1 = key MSB) for each of the 56 selected bits, C half first.
    localparam int PC1_TAB [CD_W] = '{
        57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
        10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
        63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
        14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4
    };

    // Source position (1 = MSB of the rotated C/D pair) for each subkey bit.
    localparam int PC2_TAB [SK_W] = '{
        14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
        23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
        41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
        44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32
    };

    // Rotation step of one round (1-based).
    function automatic int round_step(input int rnd);
        return (rnd == 1 || rnd == 2 || rnd == 9 || rnd == 16) ? 1 : 2;
    endfunction

    // Total left rotation applied before encryption round rnd.
    function automatic int enc_left_total(input int rnd);
        int acc;
        acc = 0;
        for (int j = 1; j <= rnd; j++) acc += round_step(j);
        return acc;
    endfunction

    // Total right rotation applied before decryption round rnd.
    function automatic int dec_right_total(input int rnd);
        int acc;
        acc = 0;
        for (int j = 1; j < rnd; j++) acc += round_step(N_ROUNDS + 1 - j);
        return acc;
    endfunction

    function automatic logic [HALF_W-1:0] rotl_half(input logic [HALF_W-1:0] v,
                                                     input int amt);
        logic [HALF_W-1:0] r;
        r = v;
        for (int i = 0; i < amt; i++) r = {r[HALF_W-2:0], r[HALF_W-1]};
        return r;
    endfunction

endpackage

// File: rtl/des_ks_pc1.sv
module des_ks_pc1
    import des_ks_pkg::*;
(
    input  logic [KEY_W-1:0] key_i,
    output logic [CD_W-1:0]  cd_o
);

    for (genvar i = 0; i < CD_W; i++) begin : g_sel
        assign cd_o[CD_W-1-i] = key_i[KEY_W - PC1_TAB[i]];
    end

endmodule

// File: rtl/des_ks_rot_pc2.sv
module des_ks_rot_pc2
    import des_ks_pkg::*;
#(
    parameter int ROUND = 1
) (
    input  logic [CD_W-1:0] cd_i,
    input  logic            decrypt_i,
    output logic [SK_W-1:0] subkey_o
);

    localparam int ENC_L = enc_left_total(ROUND) % HALF_W;
    localparam int DEC_L = (HALF_W - (dec_right_total(ROUND) % HALF_W)) % HALF_W;

    logic [HALF_W-1:0] c_half, d_half;
    logic [CD_W-1:0]   enc_cd, dec_cd, sel_cd;

    assign c_half = cd_i[CD_W-1:HALF_W];
    assign d_half = cd_i[HALF_W-1:0];

    always_comb begin
        enc_cd = {rotl_half(c_half, ENC_L), rotl_half(d_half, ENC_L)};
        dec_cd = {rotl_half(c_half, DEC_L), rotl_half(d_half, DEC_L)};
        sel_cd = decrypt_i ? dec_cd : enc_cd;
    end

    for (genvar i = 0; i < SK_W; i++) begin : g_cmp
        assign subkey_o[SK_W-1-i] = sel_cd[CD_W - PC2_TAB[i]];
    end

endmodule

// File: rtl/des_ks_align.sv
module des_ks_align #(
    parameter int DEPTH = 1,
    parameter int W     = 48
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         vld_i,
    input  logic [W-1:0] data_i,
    output logic         vld_o,
    output logic [W-1:0] data_o
);

    logic [DEPTH-1:0] vld_q;
    logic [W-1:0]     data_q [DEPTH];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            vld_q <= '0;
            for (int i = 0; i < DEPTH; i++) data_q[i] <= '0;
        end else begin
            vld_q[0]  <= vld_i;
            data_q[0] <= vld_i ? data_i : '0;
            for (int i = 1; i < DEPTH; i++) begin
                vld_q[i]  <= vld_q[i-1];
                data_q[i] <= data_q[i-1];
            end
        end
    end

    assign vld_o  = vld_q[DEPTH-1];
    assign data_o = data_q[DEPTH-1];

endmodule

// File: rtl/des_subkey_pool.sv
module des_subkey_pool
    import des_ks_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                key_vld_i,
    input  logic                key_decrypt_i,
    input  logic [KEY_W-1:0]    key_i,
    output logic [N_ROUNDS-1:0] stage_vld_o,
    output logic [POOL_W-1:0]   subkeys_o
);

    logic [CD_W-1:0] cd_sel;

    des_ks_pc1 u_pc1 (
        .key_i (key_i),
        .cd_o  (cd_sel)
    );

    for (genvar n = 1; n <= N_ROUNDS; n++) begin : g_stage
        logic [SK_W-1:0] sk_comb;

        des_ks_rot_pc2 #(.ROUND(n)) u_sk (
            .cd_i      (cd_sel),
            .decrypt_i (key_decrypt_i),
            .subkey_o  (sk_comb)
        );

        des_ks_align #(.DEPTH(n), .W(SK_W)) u_dly (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .vld_i  (key_vld_i),
            .data_i (sk_comb),
            .vld_o  (stage_vld_o[n-1]),
            .data_o (subkeys_o[(n-1)*SK_W +: SK_W])
        );
    end

endmodule

// File: rtl/des_subkey_pool_chk.sv
module des_subkey_pool_chk
    import des_ks_pkg::*;
(
    input logic                clk_i,
    input logic                rst_i,
    input logic                key_vld_i,
    input logic                key_decrypt_i,
    input logic [KEY_W-1:0]    key_i,
    input logic [N_ROUNDS-1:0] stage_vld_o,
    input logic [POOL_W-1:0]   subkeys_o
);

    p_head_fill_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        key_vld_i |=> stage_vld_o[0]);

    p_head_empty_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        !key_vld_i |=> !stage_vld_o[0]);

    // R8: reset empties all stages one edge later.
    p_reset_clear_r8: assert property (@(posedge clk_i)
        rst_i |=> (stage_vld_o == '0 && subkeys_o == '0));

    for (genvar n = 1; n < N_ROUNDS; n++) begin : g_step
        p_vld_step_r4: assert property (@(posedge clk_i) disable iff (rst_i)
            stage_vld_o[n-1] |=> stage_vld_o[n]);
    end

    for (genvar n = 0; n < N_ROUNDS; n++) begin : g_bub
        p_bubble_zero_r7: assert property (@(posedge clk_i) disable iff (rst_i)
            !stage_vld_o[n] |-> (subkeys_o[n*SK_W +: SK_W] == '0));
    end

endmodule

bind des_subkey_pool des_subkey_pool_chk u_chk (.*);

// File: tb/des_subkey_pool_tb_top.sv
`timescale 1ns/1ps
module des_subkey_pool_tb_top;

    localparam int NR = 16;
    localparam int SW = 48;
    localparam int RING = 32;
    localparam logic [63:0] PAR_MASK = 64'h0101010101010101;

    localparam int TB_PC1 [56] = '{
        57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
        10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
        63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
        14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4
    };
    localparam int TB_PC2 [48] = '{
        14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
        23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
        41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
        44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32
    };

    logic           clk = 1'b0;
    logic           rst_i = 1'b1;
    logic           key_vld_i = 1'b0;
    logic           key_decrypt_i = 1'b0;
    logic [63:0]    key_i = '0;
    logic [NR-1:0]  stage_vld_o;
    logic [NR*SW-1:0] subkeys_o;

    int n_tests = 0;
    int n_fail  = 0;
    int edge_cnt = 0;
    bit last_rst = 1'b0;
    bit stream_ph = 1'b0;
    bit done = 1'b0;

    logic        h_vld  [RING];
    logic        h_mode [RING];
    logic        h_par  [RING];
    logic [63:0] h_key  [RING];

    always #2.5 clk = ~clk;

    des_subkey_pool dut_i (
        .clk_i         (clk),
        .rst_i         (rst_i),
        .key_vld_i     (key_vld_i),
        .key_decrypt_i (key_decrypt_i),
        .key_i         (key_i),
        .stage_vld_o   (stage_vld_o),
        .subkeys_o     (subkeys_o)
    );

    // Iterative reference schedule, round by round.
    function automatic logic [47:0] ref_sk(input logic [63:0] k, input logic dec, input int n);
        logic [27:0] c, d;
        logic [55:0] cd;
        logic [47:0] r;
        int rnd;
        for (int i = 0; i < 56; i++) cd[55-i] = k[64 - TB_PC1[i]];
        c = cd[55:28];
        d = cd[27:0];
        rnd = dec ? (17 - n) : n;
        for (int j = 1; j <= rnd; j++) begin
            int s;
            s = (j == 1 || j == 2 || j == 9 || j == 16) ? 1 : 2;
            for (int t = 0; t < s; t++) begin
                c = {c[26:0], c[27]};
                d = {d[26:0], d[27]};
            end
        end
        cd = {c, d};
        for (int i = 0; i < 48; i++) r[47-i] = cd[56 - TB_PC2[i]];
        return r;
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] got,
                       input logic [63:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic check_all();
        for (int n = 1; n <= NR; n++) begin
            int idx;
            logic ev;
            logic [47:0] ek;
            string tag;
            idx = (edge_cnt - n + 1) & (RING - 1);
            ev  = h_vld[idx];
            ek  = ev ? ref_sk(h_key[idx], h_mode[idx], n) : 48'h0;
            if (last_rst)       tag = "R8";
            else if (stream_ph) tag = "R5";
            else if (!ev)       tag = "R7";
            else if (h_par[idx]) tag = "R1";
            else if (h_mode[idx]) tag = "R3";
            else                tag = "R2";
            chk(last_rst ? "R8" : "R6", $sformatf("stage %0d valid", n),
                64'(stage_vld_o[n-1]), 64'(ev));
            chk(tag, $sformatf("stage %0d subkey", n),
                64'(subkeys_o[(n-1)*SW +: SW]), 64'(ek));
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic step(input logic rst, input logic v, input logic dec,
                        input logic [63:0] drive_k, input logic [63:0] model_k,
                        input logic par);
        int idx;
        rst_i = rst;
        key_vld_i = v;
        key_decrypt_i = dec;
        key_i = drive_k;
        @(posedge clk);
        edge_cnt++;
        idx = edge_cnt & (RING - 1);
        if (rst) begin
            for (int i = 0; i < RING; i++) h_vld[i] = 1'b0;
        end else begin
            h_vld[idx]  = v;
            h_mode[idx] = dec;
            h_key[idx]  = model_k;
            h_par[idx]  = par;
        end
        last_rst = rst;
        @(negedge clk);
        check_all();
    endtask

    task automatic bubble();
        step(1'b0, 1'b0, 1'b0, 64'h0, 64'h0, 1'b0);
    endtask

    initial begin
        #1000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] kv;
        void'($urandom(32'h1234_5A5A));
        for (int i = 0; i < RING; i++) begin
            h_vld[i] = 1'b0; h_mode[i] = 1'b0; h_par[i] = 1'b0; h_key[i] = '0;
        end
        @(negedge clk);
        // reset with junk on the inputs (R8)
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, 64'hDEADBEEFCAFEF00D, 64'h0, 1'b0);
        chk("R8", "reset valid", 64'(stage_vld_o), 64'h0);

        kv = 64'h133457799BBCDFF1;
        // R2 published vector, R4 one-hot progression
        step(1'b0, 1'b1, 1'b0, kv, kv, 1'b0);
        chk("R2", "vector round1", 64'(subkeys_o[0 +: SW]), 64'h1B02EFFC7072);
        chk("R4", "onehot edge1", 64'(stage_vld_o), 64'h0001);
        for (int k = 2; k <= NR; k++) begin
            bubble();
            chk("R4", $sformatf("onehot edge%0d", k), 64'(stage_vld_o), 64'(1 << (k-1)));
        end
        chk("R2", "vector round16", 64'(subkeys_o[15*SW +: SW]), 64'hCB3D8B0E17F5);

        // R3 published vector in reverse order
        step(1'b0, 1'b1, 1'b1, kv, kv, 1'b0);
        chk("R3", "decrypt stage1", 64'(subkeys_o[0 +: SW]), 64'hCB3D8B0E17F5);
        for (int k = 2; k <= NR; k++) bubble();
        chk("R3", "decrypt stage16", 64'(subkeys_o[15*SW +: SW]), 64'h1B02EFFC7072);

        // R1 parity bits inverted, compared with the clean key's schedule
        step(1'b0, 1'b1, 1'b0, kv ^ PAR_MASK, kv, 1'b1);
        step(1'b0, 1'b1, 1'b1, kv ^ PAR_MASK, kv, 1'b1);
        for (int k = 0; k < NR; k++) bubble();

        // R5 random back-to-back stream with gaps and mixed modes
        stream_ph = 1'b1;
        for (int s = 0; s < 400; s++) begin
            logic v, m;
            logic [63:0] rk;
            v  = ($urandom % 10) < 8;
            m  = $urandom % 2;
            rk = {$urandom, $urandom};
            step(1'b0, v, m, rk, rk, 1'b0);
        end

        // R8 reset while the pipeline is full
        stream_ph = 1'b0;
        step(1'b1, 1'b1, 1'b0, 64'h0F1E2D3C4B5A6978, 64'h0, 1'b0);
        chk("R8", "midstream reset valid", 64'(stage_vld_o), 64'h0);
        for (int s = 0; s < 20; s++) begin
            logic [63:0] rk;
            rk = {$urandom, $urandom};
            step(1'b0, 1'b1, s[0], rk, rk, 1'b0);
        end
        for (int k = 0; k < NR; k++) bubble();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule